// File: doc/BRIEF.md
# Sign-Magnitude Adder

This block adds two signed operands that are held in sign-and-magnitude form and returns their sum in the same form, together with an overflow flag. Each operand and the result hold a sign bit above an unsigned magnitude field. The default magnitude width of three bits covers the values -7 to +7. The adder finds the larger magnitude and then adds or subtracts the magnitudes. It always encodes zero as positive zero. It flags overflow when two operands of the same sign produce a magnitude that does not fit.

A parameter picks the implementation. The combinational variant computes the result through a magnitude comparator, a sign selector and an add/subtract path, and its outputs follow the inputs within the same cycle. The lookup variant holds the complete result table in a memory that is filled at elaboration and read through an output register. This gives one clock of latency, and the memory maps well onto an FPGA block RAM. A synchronous active-high reset clears the register of the lookup variant.

Top module: `sm_adder`

## Requirements
- R1: Bit 3 of each operand and of `sum_o` is the sign (1 = negative) and bits 2:0 are the magnitude. A sum of two same-sign operands that fits in range comes out as the exact signed sum with `ovf_o` low.
- R2: When both operands have the same sign and their magnitudes add to more than 7, `ovf_o` is 1 and `sum_o` holds the common sign over the low three bits of the magnitude sum.
- R3: `ovf_o` is 0 whenever the operand signs differ.
- R4: When one operand has magnitude zero (of either sign), the result equals the other operand with `ovf_o` low. If the other operand is negative zero, the result is 4'b0000.
- R5: Operands of opposite sign and equal magnitude give `sum_o` = 4'b0000.
- R6: For operands of opposite sign, the result magnitude is the difference of the magnitudes and the result sign is the sign of the operand with the larger magnitude.
- R7: Every zero result without overflow is encoded as 4'b0000. A negative-zero input behaves exactly like positive zero.
- R8: With `VARIANT` = SM_LUT, `sum_o`/`ovf_o` show the result for the operands sampled at the previous rising clock edge and hold steady between edges.
- R9: With `VARIANT` = SM_LUT, a high `rst` at a rising edge sets `sum_o` to 0 and `ovf_o` to 0.
- R10: With `VARIANT` = SM_COMB, `sum_o`/`ovf_o` follow the operands with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the lookup output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 4 | Operand A, sign-and-magnitude |
| b_i | input | 4 | Operand B, sign-and-magnitude |
| sum_o | output | 4 | Sum, sign-and-magnitude |
| ovf_o | output | 1 | Overflow flag: the sum does not fit |

## Verification
The checker tests these properties on every cycle, against the operands that produced the current output:
- overflow is confined to same-sign operands;
- zero is always canonical;
- adding a zero operand is an identity;
- equal opposite magnitudes cancel;
- a mixed-sign result takes the sign of the larger magnitude.

For the lookup variant the checker compares against the operands registered one cycle earlier. Two things are shown only by the bench's scenarios. The first is the exact wrapped value produced under overflow, and the full equality with a signed reference over all 256 operand pairs. The second is the one-cycle lag and hold of the registered variant and the clearing on reset.

// File: rtl/sm_adder_pkg.sv
package sm_adder_pkg;

  // Implementation choice for the adder top
  typedef enum bit {
    SM_COMB = 1'b0,
    SM_LUT  = 1'b1
  } sm_variant_e;

  localparam int unsigned SM_MAG_W_DEF = 3;

endpackage

// File: rtl/sm_add_core.sv
module sm_add_core #(
  parameter int unsigned MAG_W = 3,
  localparam int unsigned WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);

  logic             sgn_a, sgn_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             a_ge_b;
  logic             same_sgn;
  logic [MAG_W-1:0] mag_big, mag_small;
  logic             sgn_big;
  logic [MAG_W:0]   raw;
  logic [MAG_W-1:0] res_mag;
  logic             res_sgn;

  assign sgn_a = a_i[WORD_W-1];
  assign sgn_b = b_i[WORD_W-1];
  assign mag_a = a_i[MAG_W-1:0];
  assign mag_b = b_i[MAG_W-1:0];

  // magnitude comparison decides which operand leads a subtraction
  assign a_ge_b    = (mag_a >= mag_b);
  assign same_sgn  = (sgn_a == sgn_b);
  assign mag_big   = a_ge_b ? mag_a : mag_b;
  assign mag_small = a_ge_b ? mag_b : mag_a;
  assign sgn_big   = a_ge_b ? sgn_a : sgn_b;

  always_comb begin
    if (same_sgn) raw = {1'b0, mag_a} + {1'b0, mag_b};
    else          raw = {1'b0, mag_big} - {1'b0, mag_small};
  end

  assign ovf_o   = same_sgn & raw[MAG_W];
  assign res_mag = raw[MAG_W-1:0];

  always_comb begin
    if (ovf_o)              res_sgn = sgn_a;
    else if (res_mag == '0) res_sgn = 1'b0;
    else if (same_sgn)      res_sgn = sgn_a;
    else                    res_sgn = sgn_big;
  end

  assign sum_o = {res_sgn, res_mag};

endmodule

// File: rtl/sm_add_lut.sv
module sm_add_lut #(
  parameter int unsigned MAG_W = 3,
  localparam int unsigned WORD_W = MAG_W + 1,
  localparam int unsigned ADDR_W = 2 * WORD_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned ENTRY_W = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);

  // entry = {ovf, sign, magnitude}
  function automatic logic [ENTRY_W-1:0] entry_f(input logic [ADDR_W-1:0] idx);
    logic [WORD_W-1:0] ea, eb;
    logic [MAG_W:0]    mtot;
    logic [MAG_W-1:0]  mres;
    logic              sres, ov;
    ea = idx[ADDR_W-1:WORD_W];
    eb = idx[WORD_W-1:0];
    ov = 1'b0;
    if (ea[MAG_W] == eb[MAG_W]) begin
      mtot = {1'b0, ea[MAG_W-1:0]} + {1'b0, eb[MAG_W-1:0]};
      ov   = mtot[MAG_W];
      mres = mtot[MAG_W-1:0];
      sres = ea[MAG_W];
    end else if (ea[MAG_W-1:0] >= eb[MAG_W-1:0]) begin
      mres = ea[MAG_W-1:0] - eb[MAG_W-1:0];
      sres = ea[MAG_W];
    end else begin
      mres = eb[MAG_W-1:0] - ea[MAG_W-1:0];
      sres = eb[MAG_W];
    end
    if (!ov && mres == '0) sres = 1'b0;
    return {ov, sres, mres};
  endfunction

  logic [ENTRY_W-1:0] rom [DEPTH];
  logic [ENTRY_W-1:0] rd_q;

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) rom[i] = entry_f(ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rom[{a_i, b_i}];
  end

  assign ovf_o = rd_q[ENTRY_W-1];
  assign sum_o = rd_q[WORD_W-1:0];

endmodule

// File: rtl/sm_adder.sv
module sm_adder
  import sm_adder_pkg::*;
#(
  parameter sm_variant_e VARIANT = SM_COMB,
  parameter int unsigned MAG_W   = SM_MAG_W_DEF,
  localparam int unsigned WORD_W = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);

  generate
    if (VARIANT == SM_LUT) begin : g_lut
      sm_add_lut #(.MAG_W(MAG_W)) u_lut (
        .clk  (clk),
        .rst  (rst),
        .a_i  (a_i),
        .b_i  (b_i),
        .sum_o(sum_o),
        .ovf_o(ovf_o)
      );
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      sm_add_core #(.MAG_W(MAG_W)) u_core (
        .a_i  (a_i),
        .b_i  (b_i),
        .sum_o(sum_o),
        .ovf_o(ovf_o)
      );
    end
  endgenerate

endmodule

// File: rtl/sm_adder_chk.sv
module sm_adder_chk
  import sm_adder_pkg::*;
#(
  parameter sm_variant_e VARIANT = SM_COMB,
  parameter int unsigned MAG_W   = SM_MAG_W_DEF,
  localparam int unsigned WORD_W = MAG_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] sum_o,
  input logic              ovf_o
);

  logic [WORD_W-1:0] a_q, b_q;
  logic              armed_q;
  logic [WORD_W-1:0] oa, ob;

  always_ff @(posedge clk) begin
    a_q     <= a_i;
    b_q     <= b_i;
    armed_q <= !rst;
  end

  // operands that produced the output currently visible
  assign oa = (VARIANT == SM_LUT) ? a_q : a_i;
  assign ob = (VARIANT == SM_LUT) ? b_q : b_i;

  // R3
  ovf_same_sign_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ovf_o |-> (oa[MAG_W] == ob[MAG_W]));

  // R7
  canon_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (!ovf_o && sum_o[MAG_W-1:0] == '0) |-> !sum_o[MAG_W]);

  // R4
  add_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (ob[MAG_W-1:0] == '0) |->
      (!ovf_o && sum_o == ((oa[MAG_W-1:0] == '0) ? '0 : oa)));

  // R5
  cancel_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (oa[MAG_W] != ob[MAG_W] && oa[MAG_W-1:0] == ob[MAG_W-1:0]) |->
      (!ovf_o && sum_o == '0));

  // R6
  mixed_sign_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (oa[MAG_W] != ob[MAG_W] && oa[MAG_W-1:0] > ob[MAG_W-1:0]) |->
      (sum_o[MAG_W] == oa[MAG_W]));

endmodule

bind sm_adder sm_adder_chk #(.VARIANT(VARIANT), .MAG_W(MAG_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .a_i  (a_i),
  .b_i  (b_i),
  .sum_o(sum_o),
  .ovf_o(ovf_o)
);

// File: tb/sm_adder_tb.sv
module sm_adder_tb;
  import sm_adder_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {req, a, b, ovf, sum}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd4,  4'b0011, 4'b0000, 1'b0, 4'b0011}, // R4 +3 + +0
    {4'd4,  4'b1101, 4'b1000, 1'b0, 4'b1101}, // R4 -5 + -0
    {4'd7,  4'b1000, 4'b1000, 1'b0, 4'b0000}, // R7 -0 + -0
    {4'd5,  4'b0101, 4'b1101, 1'b0, 4'b0000}, // R5 +5 + -5
    {4'd6,  4'b0110, 4'b1010, 1'b0, 4'b0100}, // R6 +6 + -2
    {4'd6,  4'b0010, 4'b1110, 1'b0, 4'b1100}, // R6 +2 + -6
    {4'd1,  4'b0011, 4'b0100, 1'b0, 4'b0111}, // R1 +3 + +4
    {4'd2,  4'b0101, 4'b0110, 1'b1, 4'b0011}, // R2 +5 + +6
    {4'd1,  4'b1010, 4'b1011, 1'b0, 4'b1101}, // R1 -2 + -3
    {4'd2,  4'b1111, 4'b1001, 1'b1, 4'b1000}, // R2 -7 + -1
    {4'd2,  4'b0111, 4'b0111, 1'b1, 4'b0110}, // R2 +7 + +7
    {4'd3,  4'b1111, 4'b0111, 1'b0, 4'b0000}, // R3 -7 + +7
    {4'd7,  4'b0000, 4'b1000, 1'b0, 4'b0000}, // R7 +0 + -0
    {4'd6,  4'b1001, 4'b0011, 1'b0, 4'b0010}  // R6 -1 + +3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [3:0] sum_c, sum_r;
  logic       ovf_c, ovf_r;
  int checks = 0;
  int errors = 0;
  logic [4:0] prev_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_adder #(.VARIANT(SM_COMB)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sum_o(sum_c), .ovf_o(ovf_c));

  sm_adder #(.VARIANT(SM_LUT)) u_dut_reg (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sum_o(sum_r), .ovf_o(ovf_r));

  // signed reference: returns {ovf, sum}
  function automatic logic [4:0] ref_f(input logic [3:0] x, input logic [3:0] y);
    int vx, vy, t, m;
    vx = x[3] ? -int'(x[2:0]) : int'(x[2:0]);
    vy = y[3] ? -int'(y[2:0]) : int'(y[2:0]);
    t  = vx + vy;
    m  = (t < 0) ? -t : t;
    if (m > 7) return {1'b1, (t < 0), 3'(m % 8)};
    return {1'b0, (t < 0), 3'(m)};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got ovf=%b sum=%b, expected ovf=%b sum=%b",
               tag, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  // drive at negedge; comb checked in same cycle, registered held then updated
  task automatic apply(input logic [3:0] x, input logic [3:0] y,
                       input logic [4:0] exp, input string tag);
    @(negedge clk);
    a = x; b = y;
    #1;
    check({tag, " comb R10"}, {ovf_c, sum_c}, exp);
    check({tag, " reg hold R8"}, {ovf_r, sum_r}, prev_exp);
    @(posedge clk);
    #1;
    check({tag, " reg R8"}, {ovf_r, sum_r}, exp);
    prev_exp = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = 4'b0111; b = 4'b0111;
    repeat (2) @(posedge clk);
    #1;
    check("reset R9", {ovf_r, sum_r}, 5'b0);
    prev_exp = 5'b0;
    @(negedge clk);
    rst = 1'b0;
    a = '0; b = '0;
    @(posedge clk);
    #1;
    prev_exp = ref_f(4'b0000, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][12:9], VEC[i][8:5], VEC[i][4:0],
            $sformatf("table %0d R%0d", i, VEC[i][16:13]));
    end

    // full sweep against the signed reference (R1 R2 R3 R6 R7)
    for (int i = 0; i < 256; i++) begin
      apply(4'(i >> 4), 4'(i), ref_f(4'(i >> 4), 4'(i)),
            $sformatf("sweep a=%b b=%b R1", 4'(i >> 4), 4'(i)));
    end

    // reset mid-run clears the registered output (R9)
    @(negedge clk);
    a = 4'b0110; b = 4'b0101;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("mid reset R9", {ovf_r, sum_r}, 5'b0);
    check("comb under reset R10", {ovf_c, sum_c}, ref_f(4'b0110, 4'b0101));
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("after reset R8", {ovf_r, sum_r}, ref_f(4'b0110, 4'b0101));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule